// File: doc/BRIEF.md
# Priority Reference Clock Selector

The selector picks one reference input, out of twelve, for a clock-recovery loop to track. A separate validation stage reports which inputs are currently qualified. For each input, configuration supplies an active-low participation bit and a 4-bit priority code. An input is a candidate only when it is qualified, its participation bit is low and its priority code is non-zero. Among the candidates, the smallest non-zero code wins.

A mode bit chooses between two re-selection rules. With revertive switching on, the selector moves to any candidate that outranks the current one. With it off, the selector keeps a working reference until that reference drops out. When no input can be used, the valid flag goes low and the last index is kept. A one-cycle strobe marks every change of the selected index.

All outputs are registered and update one clock after the inputs that cause them.

Top module: `ref_clk_selector`

## Requirements
- R1: Input k (1..12) is a candidate only when `qual[k-1]`=1, `lockout[k-1]`=0 and its priority code, bits `prio_cfg[(k-1)*4 +: 4]`, is non-zero. An input that fails any of these has no effect on the outputs.
- R2: Among the candidates, the one with the numerically smallest priority code is the best. On equal codes, the lower index wins.
- R3: When `sel_valid` is 0 and at least one candidate exists, on the next clock `sel_idx` takes the best candidate and `sel_valid` goes to 1.
- R4: With `revertive`=1 and the current input still a candidate, the selector moves on the next clock to a candidate whose code is strictly smaller than the current input's code. A candidate with an equal or larger code causes no move.
- R5: With `revertive`=0 and the current input still a candidate, `sel_idx` stays unchanged, whatever other inputs appear.
- R6: When the current input stops being a candidate and other candidates exist, `sel_idx` moves on the next clock to the best of them. This holds in both modes.
- R7: When no candidate exists, `sel_valid` goes to 0 on the next clock and `sel_idx` keeps its last value.
- R8: `sel_switch` is 1 for exactly the one cycle in which `sel_idx` shows a new value. Otherwise it is 0.
- R9: While `rst_n` is low, `sel_idx`=0, `sel_valid`=0 and `sel_switch`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| qual | input | 12 | Per-input qualification from the validation stage; bit k-1 belongs to input k |
| lockout | input | 12 | Per-input participation bit, active low: 0 lets the input take part |
| prio_cfg | input | 48 | Four bits of priority per input; 0 excludes the input and 1 is the highest priority |
| revertive | input | 1 | 1 selects revertive switching, 0 selects non-revertive switching |
| sel_idx | output | 4 | Selected input index 1..12; 0 only before the first selection |
| sel_valid | output | 1 | High while a usable input is selected |
| sel_switch | output | 1 | One-cycle strobe on a change of `sel_idx` |

## Verification
Some properties are checked on every cycle:
- a candidate always leads to a valid selection;
- no candidate clears the valid flag and holds the index;
- a selected input is kept in non-revertive mode;
- loss of the current input moves the selection to the best remaining candidate;
- the strobe coincides exactly with index changes;
- the arbiter's grant is one-hot whenever a candidate exists.

Other behaviours only the bench's scenarios can show:
- priority ordering and the lower-index tie rule;
- a zero code or a set participation bit excluding an input;
- revertive mode ignoring an equal-priority newcomer while taking a strictly better one.

A behavioural reference model in the bench covers these through directed steps and a long stretch of random qualification and configuration changes.

// File: rtl/ref_sel_pkg.sv
package ref_sel_pkg;
  localparam int DEF_N_REF  = 12;
  localparam int DEF_PRIO_W = 4;

  // Index width holding 0 (none) through n.
  function automatic int idx_width(input int n);
    return $clog2(n + 1);
  endfunction

  // A code outranks another when it is numerically smaller.
  function automatic logic outranks(input logic [DEF_PRIO_W-1:0] a,
                                    input logic [DEF_PRIO_W-1:0] b);
    return a < b;
  endfunction
endpackage

// File: rtl/ref_sel_eligible.sv
module ref_sel_eligible
  import ref_sel_pkg::*;
#(
  parameter int N_REF  = DEF_N_REF,
  parameter int PRIO_W = DEF_PRIO_W
) (
  input  logic [N_REF-1:0]        qual,
  input  logic [N_REF-1:0]        lockout,
  input  logic [N_REF*PRIO_W-1:0] prio_cfg,
  output logic [N_REF-1:0]        elig
);
  for (genvar g = 0; g < N_REF; g++) begin : g_elig
    // R1: qualified, allowed and holding a non-zero code
    assign elig[g] = qual[g] & ~lockout[g] & (|prio_cfg[g*PRIO_W +: PRIO_W]);
  end
endmodule

// File: rtl/ref_sel_arbiter.sv
module ref_sel_arbiter
  import ref_sel_pkg::*;
#(
  parameter int N_REF  = DEF_N_REF,
  parameter int PRIO_W = DEF_PRIO_W,
  localparam int IDX_W = idx_width(N_REF)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_REF-1:0]        elig,
  input  logic [N_REF*PRIO_W-1:0] prio_cfg,
  output logic [N_REF-1:0]        grant,
  output logic [IDX_W-1:0]        best_idx,
  output logic [PRIO_W-1:0]       best_prio,
  output logic                    any_elig
);
  logic [PRIO_W-1:0] code;

  // R2: scan from the lowest index; a strict compare keeps the lower index on ties
  always_comb begin
    grant     = '0;
    best_idx  = '0;
    best_prio = '1;
    any_elig  = 1'b0;
    code      = '0;
    for (int i = 0; i < N_REF; i++) begin
      code = prio_cfg[i*PRIO_W +: PRIO_W];
      if (elig[i] && (!any_elig || outranks(code, best_prio))) begin
        grant     = '0;
        grant[i]  = 1'b1;
        best_idx  = IDX_W'(i + 1);
        best_prio = code;
        any_elig  = 1'b1;
      end
    end
  end

  p_grant_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|elig) |-> $onehot(grant));
  p_grant_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(|elig) |-> (grant == '0));
endmodule

// File: rtl/ref_sel_state.sv
module ref_sel_state
  import ref_sel_pkg::*;
#(
  parameter int N_REF  = DEF_N_REF,
  parameter int PRIO_W = DEF_PRIO_W,
  localparam int IDX_W = idx_width(N_REF)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    revertive,
  input  logic [N_REF-1:0]        elig,
  input  logic [N_REF*PRIO_W-1:0] prio_cfg,
  input  logic [IDX_W-1:0]        best_idx,
  input  logic [PRIO_W-1:0]       best_prio,
  input  logic                    any_elig,
  output logic [IDX_W-1:0]        sel_idx,
  output logic                    sel_valid,
  output logic                    sel_switch
);
  logic              cur_elig;
  logic [PRIO_W-1:0] cur_prio;
  logic              better_seen;
  logic [IDX_W-1:0]  nxt_idx;
  logic              nxt_valid;

  // Look up the current input's candidacy and code
  always_comb begin
    cur_elig = 1'b0;
    cur_prio = '0;
    for (int i = 0; i < N_REF; i++) begin
      if (sel_idx == IDX_W'(i + 1)) begin
        cur_elig = sel_valid & elig[i];
        cur_prio = prio_cfg[i*PRIO_W +: PRIO_W];
      end
    end
  end

  assign better_seen = any_elig && outranks(best_prio, cur_prio);

  always_comb begin
    if (cur_elig) begin
      nxt_valid = 1'b1;
      nxt_idx   = (revertive && better_seen) ? best_idx : sel_idx;  // R4, R5
    end else if (any_elig) begin
      nxt_valid = 1'b1;                                             // R3, R6
      nxt_idx   = best_idx;
    end else begin
      nxt_valid = 1'b0;                                             // R7
      nxt_idx   = sel_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_idx    <= '0;
      sel_valid  <= 1'b0;
      sel_switch <= 1'b0;
    end else begin
      sel_idx    <= nxt_idx;
      sel_valid  <= nxt_valid;
      sel_switch <= (nxt_idx != sel_idx);                           // R8
    end
  end

  p_acquire_r3: assert property (@(posedge clk) disable iff (!rst_n)
    any_elig |=> sel_valid);
  p_none_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !any_elig |=> (!sel_valid && $stable(sel_idx)));
  p_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!revertive && cur_elig) |=> $stable(sel_idx));
  p_leave_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_valid && !cur_elig && any_elig) |=> (sel_idx == $past(best_idx)));
  p_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sel_switch |-> (sel_idx != $past(sel_idx)));
  p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_switch |-> $stable(sel_idx));
endmodule

// File: rtl/ref_clk_selector.sv
module ref_clk_selector
  import ref_sel_pkg::*;
#(
  parameter int N_REF  = DEF_N_REF,
  parameter int PRIO_W = DEF_PRIO_W,
  localparam int IDX_W = idx_width(N_REF)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_REF-1:0]        qual,
  input  logic [N_REF-1:0]        lockout,
  input  logic [N_REF*PRIO_W-1:0] prio_cfg,
  input  logic                    revertive,
  output logic [IDX_W-1:0]        sel_idx,
  output logic                    sel_valid,
  output logic                    sel_switch
);
  logic [N_REF-1:0]  elig;
  logic [N_REF-1:0]  grant;
  logic [IDX_W-1:0]  best_idx;
  logic [PRIO_W-1:0] best_prio;
  logic              any_elig;

  ref_sel_eligible #(.N_REF(N_REF), .PRIO_W(PRIO_W)) u_elig (
    .qual(qual), .lockout(lockout), .prio_cfg(prio_cfg), .elig(elig)
  );

  ref_sel_arbiter #(.N_REF(N_REF), .PRIO_W(PRIO_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .elig(elig), .prio_cfg(prio_cfg),
    .grant(grant), .best_idx(best_idx), .best_prio(best_prio),
    .any_elig(any_elig)
  );

  ref_sel_state #(.N_REF(N_REF), .PRIO_W(PRIO_W)) u_state (
    .clk(clk), .rst_n(rst_n), .revertive(revertive), .elig(elig),
    .prio_cfg(prio_cfg), .best_idx(best_idx), .best_prio(best_prio),
    .any_elig(any_elig), .sel_idx(sel_idx), .sel_valid(sel_valid),
    .sel_switch(sel_switch)
  );
endmodule

// File: tb/tb_ref_clk_selector.sv
`timescale 1ns/1ps
module tb_ref_clk_selector;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] qual = '0;
  logic [11:0] lockout = '1;
  logic [47:0] prio_cfg = '0;
  logic        revertive = 1'b1;
  logic [3:0]  sel_idx;
  logic        sel_valid;
  logic        sel_switch;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // Reference model state
  int m_idx = 0;
  bit m_valid = 0;
  bit m_sw = 0;

  always #5 clk = ~clk;

  ref_clk_selector dut (
    .clk(clk), .rst_n(rst_n), .qual(qual), .lockout(lockout),
    .prio_cfg(prio_cfg), .revertive(revertive), .sel_idx(sel_idx),
    .sel_valid(sel_valid), .sel_switch(sel_switch)
  );

  function automatic int code_of(int k);
    return int'(prio_cfg[(k-1)*4 +: 4]);
  endfunction

  function automatic bit cand(int k);
    return qual[k-1] && !lockout[k-1] && code_of(k) != 0;
  endfunction

  // Best candidate: smallest code, first found on ties; 0 when none.
  function automatic int best_of();
    int b = 0;
    for (int k = 1; k <= 12; k++)
      if (cand(k) && (b == 0 || code_of(k) < code_of(b))) b = k;
    return b;
  endfunction

  task automatic model_step();
    int b = best_of();
    int nidx = m_idx;
    bit nval;
    if (m_valid && cand(m_idx)) begin
      nval = 1;
      if (revertive && b != 0 && code_of(b) < code_of(m_idx)) nidx = b;
    end else if (b != 0) begin
      nval = 1;
      nidx = b;
    end else begin
      nval = 0;
    end
    m_sw = (nidx != m_idx);
    m_idx = nidx;
    m_valid = nval;
  endtask

  task automatic compare(string tag);
    checks++;
    if (sel_idx !== 4'(m_idx) || sel_valid !== m_valid || sel_switch !== m_sw) begin
      fails++;
      $display("FAIL %s: idx/valid/switch actual %0d/%0b/%0b expected %0d/%0b/%0b",
               tag, sel_idx, sel_valid, sel_switch, m_idx, m_valid, m_sw);
    end
  endtask

  // Inputs are already set at a falling edge; clock once and compare
  task automatic step(string tag);
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic set_prio(int k, int c);
    prio_cfg[(k-1)*4 +: 4] = 4'(c);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R9 reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R9 after release");

    // R1: every input qualified with codes, but all locked out
    qual = '1;
    for (int k = 1; k <= 12; k++) set_prio(k, k + 2);
    step("R1 locked out");
    step("R1 locked out hold");

    // R3/R2: unlock inputs 3 and 7; 7 holds the smaller code
    lockout[2] = 1'b0; lockout[6] = 1'b0;
    set_prio(3, 5); set_prio(7, 2);
    step("R3 acquire best");
    step("R8 strobe drops");

    // R1/R6: a zero code removes input 7
    set_prio(7, 0);
    step("R6 zero code leaves");

    // R4: equal code on input 5 does not move revertive selection
    lockout[4] = 1'b0; set_prio(5, 5);
    step("R4 equal code ignored");
    // R4: strictly better input 9 takes over
    lockout[8] = 1'b0; set_prio(9, 1);
    step("R4 revert to better");

    // R6/R2: lose 9; tie between 3 and 5 goes to 3
    qual[8] = 1'b0;
    step("R2 tie lower index");

    // R5: non-revertive keeps input 3 when 9 returns
    revertive = 1'b0;
    qual[8] = 1'b1;
    step("R5 keep current");
    step("R5 keep current again");
    // R6: disqualify 3 in non-revertive mode -> best is 9
    qual[2] = 1'b0;
    step("R6 leave in non-revertive");

    // R1: lockout on 9 -> moves to 5
    lockout[8] = 1'b1;
    step("R1 lockout removes");

    // R7: nothing qualified -> invalid, index held
    qual = '0;
    step("R7 none eligible");
    step("R7 hold index");
    // R3: recovery reacquires best
    qual = '1;
    step("R3 reacquire");

    // Random stretch, both modes
    for (int n = 0; n < 3000; n++) begin
      if (($urandom % 4) == 0) qual[$urandom % 12] = ~qual[$urandom % 12];
      if (($urandom % 10) == 0) lockout[$urandom % 12] = $urandom % 3 == 0;
      if (($urandom % 16) == 0) set_prio(($urandom % 12) + 1, $urandom % 16);
      if (($urandom % 50) == 0) revertive = ~revertive;
      step("R4 R5 R6 R8 random");
    end

    // R9: reset mid-run
    rst_n = 1'b0;
    m_idx = 0; m_valid = 0; m_sw = 0;
    #1;
    compare("R9 reset mid-run");
    finish_run();
  end
endmodule